// File: doc/BRIEF.md
# Flash Program Sequence Error Checker

This block sits beside an embedded flash controller. It watches the four control bits (program, fast program, page erase, mass erase), the word write strobes with their byte addresses, and the completion events of page and mass erases. From these it raises three sticky error flags: a sequence flag, an alignment flag and a fast-page miss flag. When software starts an erase that security forbids, the block answers with a one-cycle illegal-access pulse and raises no flag.

A control bit is taken as "set" on the cycle its level rises. An erase rise is judged with the `sec_ok` input sampled in the same cycle. Every flag and the pulse are registered, so they change on the clock edge after the event that causes them. Software clears flags by pulsing `clr_we` with a per-bit mask. Addresses are byte addresses. A double-word is 8 bytes, a row is 256 bytes and a page is 2 KiB. Each of these sizes is a parameter.

Top module: `flash_seq_guard`

## Requirements
- R1: In standard programming (`ctl_prog`=1, `ctl_fast`=0), the first write of a pair must have `wr_addr[2:0]`=0, and the second write must have the same `wr_addr[AW-1:3]` as the first. A violation raises `err_align`. A misaligned first write does not start a pair.
- R2: In fast programming (`ctl_fast`=1), every write after the first must have the same `wr_addr[AW-1:8]` as the previous write and a strictly greater address. Otherwise `err_align` rises. The history restarts when `ctl_fast` falls.
- R3: A write while both `ctl_prog` and `ctl_fast` are 0 raises `err_seq`.
- R4: A rise of `ctl_prog` or `ctl_fast` while `ctl_perase` or `ctl_merase` is 1 raises `err_seq`.
- R5: A rise of `ctl_fast` when no `merase_done` has been seen since reset raises `err_seq`.
- R6: A rise of `ctl_merase` while `ctl_prog`, `ctl_fast` or `ctl_perase` is 1 raises `err_seq` when `sec_ok`=1.
- R7: A rise of `ctl_perase` or `ctl_merase` with `sec_ok`=0 produces a one-cycle `illegal_pulse` on the next cycle and sets no flag for that erase.
- R8: A write, or a permitted rise of any control bit, while any error flag is already set raises `err_seq`.
- R9: A fast write whose page (`wr_addr[AW-1:11]`) is not covered raises `err_miss`. After a page erase, the page must equal the erased page. After a mass erase, the page must be at least the page of the last fast write (0 right after the mass erase).
- R10: A rise of `ctl_perase` while `ctl_prog`, `ctl_fast` or `ctl_merase` is 1 raises `err_seq` when `sec_ok`=1.
- R11: Flags stay set until `clr_we`=1 with a 1 in their mask bit (bit 2 seq, bit 1 align, bit 0 miss). A set and a clear of the same flag in one cycle leave the flag set.
- R12: Synchronous reset clears all flags, the pulse and the erase history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_prog | input | 1 | Standard program enable level |
| ctl_fast | input | 1 | Fast program enable level |
| ctl_perase | input | 1 | Page erase request level |
| ctl_merase | input | 1 | Mass erase request level |
| sec_ok | input | 1 | Security allows the erase starting this cycle |
| wr_en | input | 1 | Data write strobe |
| wr_addr | input | AW | Byte address of the write |
| perase_done | input | 1 | A page erase has finished |
| perase_page | input | AW-PAGE_LSB | Index of the erased page |
| merase_done | input | 1 | A mass erase has finished |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | 3 | Write-one-to-clear mask {seq, align, miss} |
| err_seq | output | 1 | Sticky sequence error |
| err_align | output | 1 | Sticky alignment error |
| err_miss | output | 1 | Sticky fast-page miss error |
| illegal_pulse | output | 1 | One-cycle illegal-access event |

## Verification
Setting a flag and clearing it can happen in the same cycle. The bench provokes this with a write that has no program enable while a flag is already set, and in that same cycle it pulses `clr_we` with the sequence bit in the mask. The flag must read 1 on the next cycle. A denied erase rise and an ordinary sequence check can also coincide: a page erase rises with `sec_ok`=0 while program is set. The bench then expects the pulse and no flag.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    ERS_NONE = 2'd0,
    ERS_PAGE = 2'd1,
    ERS_MASS = 2'd2
  } ers_kind_e;

  localparam int NFLAG      = 3;
  localparam int FLAG_SEQ   = 2;
  localparam int FLAG_ALIGN = 1;
  localparam int FLAG_MISS  = 0;
endpackage

// File: rtl/fsg_ctl_watch.sv
module fsg_ctl_watch (
  input  logic clk,
  input  logic rst,
  input  logic ctl_prog,
  input  logic ctl_fast,
  input  logic ctl_perase,
  input  logic ctl_merase,
  input  logic sec_ok,
  input  logic wr_en,
  input  logic any_err,
  input  logic mass_seen,
  output logic seq_hit,
  output logic deny_hit
);
  logic prev_prog, prev_fast, prev_pe, prev_me;
  logic rise_prog, rise_fast, rise_pe, rise_me;
  logic pgm_rise, ers_rise;
  logic s_nowen, s_pgm_conf, s_fast_early, s_me_conf, s_pe_conf, s_stale;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_prog <= 1'b0;
      prev_fast <= 1'b0;
      prev_pe   <= 1'b0;
      prev_me   <= 1'b0;
    end else begin
      prev_prog <= ctl_prog;
      prev_fast <= ctl_fast;
      prev_pe   <= ctl_perase;
      prev_me   <= ctl_merase;
    end
  end

  always_comb begin
    rise_prog    = ctl_prog   & ~prev_prog;
    rise_fast    = ctl_fast   & ~prev_fast;
    rise_pe      = ctl_perase & ~prev_pe;
    rise_me      = ctl_merase & ~prev_me;
    pgm_rise     = rise_prog | rise_fast;
    ers_rise     = rise_pe | rise_me;
    deny_hit     = ers_rise & ~sec_ok;
    s_nowen      = wr_en & ~ctl_prog & ~ctl_fast;
    s_pgm_conf   = pgm_rise & (ctl_perase | ctl_merase);
    s_fast_early = rise_fast & ~mass_seen;
    s_me_conf    = rise_me & (ctl_prog | ctl_fast | ctl_perase) & sec_ok;
    s_pe_conf    = rise_pe & (ctl_prog | ctl_fast | ctl_merase) & sec_ok;
    s_stale      = any_err & (pgm_rise | wr_en | (ers_rise & sec_ok));
    seq_hit      = s_nowen | s_pgm_conf | s_fast_early | s_me_conf
                 | s_pe_conf | s_stale;
  end
endmodule

// File: rtl/fsg_write_track.sv
module fsg_write_track
  import flash_seq_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW_LSB   = 3,
  parameter int ROW_LSB  = 8,
  parameter int PAGE_LSB = 11
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ctl_prog,
  input  logic                   ctl_fast,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic                   perase_done,
  input  logic [AW-PAGE_LSB-1:0] perase_page,
  input  logic                   merase_done,
  output logic                   align_hit,
  output logic                   miss_hit,
  output logic                   mass_seen
);
  localparam int PGW = AW - PAGE_LSB;
  localparam int DWW = AW - DW_LSB;
  localparam int RWW = AW - ROW_LSB;

  logic            std_half;
  logic [DWW-1:0]  std_dw;
  logic            fp_valid;
  logic [AW-1:0]   fp_addr;
  ers_kind_e       ers_kind;
  logic [PGW-1:0]  ers_page;
  logic [PGW-1:0]  last_pg;

  logic            std_wr, fast_wr, first_ok, page_ok;
  logic [DWW-1:0]  wr_dw;
  logic [RWW-1:0]  wr_row, fp_row;
  logic [PGW-1:0]  wr_page;

  always_comb begin
    std_wr   = wr_en & ctl_prog & ~ctl_fast;
    fast_wr  = wr_en & ctl_fast;
    wr_dw    = wr_addr[AW-1:DW_LSB];
    wr_row   = wr_addr[AW-1:ROW_LSB];
    fp_row   = fp_addr[AW-1:ROW_LSB];
    wr_page  = wr_addr[AW-1:PAGE_LSB];
    first_ok = (wr_addr[DW_LSB-1:0] == '0);
    unique case (ers_kind)
      ERS_PAGE: page_ok = (wr_page == ers_page);
      ERS_MASS: page_ok = (wr_page >= last_pg);
      default:  page_ok = 1'b0;
    endcase
    align_hit = (std_wr & ~std_half & ~first_ok)
              | (std_wr & std_half & (wr_dw != std_dw))
              | (fast_wr & fp_valid & ((wr_row != fp_row) | (wr_addr <= fp_addr)));
    miss_hit  = fast_wr & ~page_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      std_half  <= 1'b0;
      std_dw    <= '0;
      fp_valid  <= 1'b0;
      fp_addr   <= '0;
      ers_kind  <= ERS_NONE;
      ers_page  <= '0;
      last_pg   <= '0;
      mass_seen <= 1'b0;
    end else begin
      if (!ctl_prog || ctl_fast) begin
        std_half <= 1'b0;
      end else if (std_wr) begin
        if (!std_half && first_ok) begin
          std_half <= 1'b1;
          std_dw   <= wr_dw;
        end else begin
          std_half <= 1'b0;
        end
      end

      if (!ctl_fast) begin
        fp_valid <= 1'b0;
      end else if (fast_wr) begin
        fp_valid <= 1'b1;
        fp_addr  <= wr_addr;
      end

      if (merase_done) begin
        ers_kind  <= ERS_MASS;
        mass_seen <= 1'b1;
        last_pg   <= '0;
      end else begin
        if (perase_done) begin
          ers_kind <= ERS_PAGE;
          ers_page <= perase_page;
        end
        if (fast_wr) begin
          last_pg <= wr_page;
        end
      end
    end
  end
endmodule

// File: rtl/fsg_flag_bank.sv
module fsg_flag_bank
  import flash_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_vec,
  input  logic             clr_we,
  input  logic [NFLAG-1:0] clr_mask,
  input  logic             deny_hit,
  output logic [NFLAG-1:0] flags,
  output logic             illegal_pulse
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flags[i] <= 1'b0;
      end else begin
        flags[i] <= (flags[i] & ~(clr_we & clr_mask[i])) | set_vec[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) illegal_pulse <= 1'b0;
    else     illegal_pulse <= deny_hit;
  end
endmodule

// File: rtl/flash_seq_guard.sv
module flash_seq_guard
  import flash_seq_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW_LSB   = 3,
  parameter int ROW_LSB  = 8,
  parameter int PAGE_LSB = 11
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ctl_prog,
  input  logic                   ctl_fast,
  input  logic                   ctl_perase,
  input  logic                   ctl_merase,
  input  logic                   sec_ok,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic                   perase_done,
  input  logic [AW-PAGE_LSB-1:0] perase_page,
  input  logic                   merase_done,
  input  logic                   clr_we,
  input  logic [2:0]             clr_mask,
  output logic                   err_seq,
  output logic                   err_align,
  output logic                   err_miss,
  output logic                   illegal_pulse
);
  logic             seq_hit, deny_hit, align_hit, miss_hit, mass_seen, any_err;
  logic [NFLAG-1:0] set_vec, flags;

  assign any_err = |flags;

  fsg_ctl_watch u_ctl (
    .clk        (clk),
    .rst        (rst),
    .ctl_prog   (ctl_prog),
    .ctl_fast   (ctl_fast),
    .ctl_perase (ctl_perase),
    .ctl_merase (ctl_merase),
    .sec_ok     (sec_ok),
    .wr_en      (wr_en),
    .any_err    (any_err),
    .mass_seen  (mass_seen),
    .seq_hit    (seq_hit),
    .deny_hit   (deny_hit)
  );

  fsg_write_track #(
    .AW       (AW),
    .DW_LSB   (DW_LSB),
    .ROW_LSB  (ROW_LSB),
    .PAGE_LSB (PAGE_LSB)
  ) u_wr (
    .clk         (clk),
    .rst         (rst),
    .ctl_prog    (ctl_prog),
    .ctl_fast    (ctl_fast),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .perase_done (perase_done),
    .perase_page (perase_page),
    .merase_done (merase_done),
    .align_hit   (align_hit),
    .miss_hit    (miss_hit),
    .mass_seen   (mass_seen)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[FLAG_SEQ]   = seq_hit;
    set_vec[FLAG_ALIGN] = align_hit;
    set_vec[FLAG_MISS]  = miss_hit;
  end

  fsg_flag_bank u_flags (
    .clk           (clk),
    .rst           (rst),
    .set_vec       (set_vec),
    .clr_we        (clr_we),
    .clr_mask      (clr_mask),
    .deny_hit      (deny_hit),
    .flags         (flags),
    .illegal_pulse (illegal_pulse)
  );

  assign err_seq   = flags[FLAG_SEQ];
  assign err_align = flags[FLAG_ALIGN];
  assign err_miss  = flags[FLAG_MISS];
endmodule

// File: rtl/flash_seq_guard_chk.sv
module flash_seq_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       ctl_prog,
  input logic       ctl_fast,
  input logic       wr_en,
  input logic       sec_ok,
  input logic       clr_we,
  input logic [2:0] clr_mask,
  input logic       err_seq,
  input logic       err_align,
  input logic       err_miss,
  input logic       illegal_pulse
);
  // R3
  nowen_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ctl_prog && !ctl_fast) |=> err_seq);

  // R7
  deny_needs_sec_low_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_pulse |-> !$past(sec_ok));

  // R11
  seq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_seq && !(clr_we && clr_mask[2])) |=> err_seq);

  // R11
  align_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_align && !(clr_we && clr_mask[1])) |=> err_align);

  // R11
  miss_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_miss && !(clr_we && clr_mask[0])) |=> err_miss);

  // R12
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!err_seq && !err_align && !err_miss && !illegal_pulse));
endmodule

bind flash_seq_guard flash_seq_guard_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .ctl_prog      (ctl_prog),
  .ctl_fast      (ctl_fast),
  .wr_en         (wr_en),
  .sec_ok        (sec_ok),
  .clr_we        (clr_we),
  .clr_mask      (clr_mask),
  .err_seq       (err_seq),
  .err_align     (err_align),
  .err_miss      (err_miss),
  .illegal_pulse (illegal_pulse)
);

// File: tb/flash_seq_guard_bench.sv
module flash_seq_guard_bench;
  typedef struct packed {
    logic [3:0]  ctl;   // {prog, fast, perase, merase}
    logic        sec;
    logic        wr;
    logic [15:0] addr;
    logic        pd;
    logic [4:0]  pp;
    logic        md;
    logic [2:0]  clr;   // {seq, align, miss}
    logic [2:0]  ef;    // expected {seq, align, miss}
    logic        ei;    // expected illegal pulse
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 51;
  localparam vec_t VEC [NV] = '{
    '{4'b0000,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b000,1'b0,4'd12}, // R12 idle
    '{4'b0000,1'b1,1'b1,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b100,1'b0,4'd3},  // R3
    '{4'b0000,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b111,3'b000,1'b0,4'd11}, // R11
    '{4'b1000,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b000,1'b0,4'd4},  // R4 clean rise
    '{4'b1000,1'b1,1'b1,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b000,1'b0,4'd1},  // R1
    '{4'b1000,1'b1,1'b1,16'h0004,1'b0,5'd0,1'b0,3'b000,3'b000,1'b0,4'd1},  // R1
    '{4'b1000,1'b1,1'b1,16'h0012,1'b0,5'd0,1'b0,3'b000,3'b010,1'b0,4'd1},  // R1
    '{4'b1000,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b111,3'b000,1'b0,4'd11}, // R11
    '{4'b1000,1'b1,1'b1,16'h0020,1'b0,5'd0,1'b0,3'b000,3'b000,1'b0,4'd1},  // R1
    '{4'b1000,1'b1,1'b1,16'h0028,1'b0,5'd0,1'b0,3'b000,3'b010,1'b0,4'd1},  // R1
    '{4'b0000,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b111,3'b000,1'b0,4'd11}, // R11
    '{4'b0001,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b000,1'b0,4'd6},  // R6
    '{4'b1001,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b100,1'b0,4'd4},  // R4
    '{4'b0000,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b111,3'b000,1'b0,4'd11}, // R11
    '{4'b0010,1'b0,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b000,1'b1,4'd7},  // R7
    '{4'b0011,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b100,1'b0,4'd6},  // R6
    '{4'b0000,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b111,3'b000,1'b0,4'd11}, // R11
    '{4'b1000,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b000,1'b0,4'd4},  // R4
    '{4'b1010,1'b0,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b000,1'b1,4'd7},  // R7
    '{4'b1010,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b000,1'b0,4'd7},  // R7 single
    '{4'b1000,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b000,1'b0,4'd10}, // R10
    '{4'b1010,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b100,1'b0,4'd10}, // R10
    '{4'b0000,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b111,3'b000,1'b0,4'd11}, // R11
    '{4'b0100,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b100,1'b0,4'd5},  // R5
    '{4'b0000,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b111,3'b000,1'b0,4'd11}, // R11
    '{4'b0000,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b1,3'b000,3'b000,1'b0,4'd9},  // R9 mass done
    '{4'b0100,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b000,1'b0,4'd5},  // R5
    '{4'b0100,1'b1,1'b1,16'h0100,1'b0,5'd0,1'b0,3'b000,3'b000,1'b0,4'd2},  // R2
    '{4'b0100,1'b1,1'b1,16'h0108,1'b0,5'd0,1'b0,3'b000,3'b000,1'b0,4'd2},  // R2
    '{4'b0100,1'b1,1'b1,16'h0108,1'b0,5'd0,1'b0,3'b000,3'b010,1'b0,4'd2},  // R2 not greater
    '{4'b0100,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b111,3'b000,1'b0,4'd11}, // R11
    '{4'b0100,1'b1,1'b1,16'h0200,1'b0,5'd0,1'b0,3'b000,3'b010,1'b0,4'd2},  // R2 new row
    '{4'b0100,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b111,3'b000,1'b0,4'd11}, // R11
    '{4'b0000,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b000,1'b0,4'd2},  // R2
    '{4'b0100,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b000,1'b0,4'd9},  // R9
    '{4'b0100,1'b1,1'b1,16'h1000,1'b0,5'd0,1'b0,3'b000,3'b000,1'b0,4'd9},  // R9 page 2
    '{4'b0000,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b000,1'b0,4'd9},  // R9
    '{4'b0100,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b000,1'b0,4'd9},  // R9
    '{4'b0100,1'b1,1'b1,16'h0800,1'b0,5'd0,1'b0,3'b000,3'b001,1'b0,4'd9},  // R9 lower page
    '{4'b0000,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b111,3'b000,1'b0,4'd11}, // R11
    '{4'b0000,1'b1,1'b0,16'h0000,1'b1,5'd3,1'b0,3'b000,3'b000,1'b0,4'd9},  // R9 page 3 erased
    '{4'b0100,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b000,1'b0,4'd9},  // R9
    '{4'b0100,1'b1,1'b1,16'h1800,1'b0,5'd0,1'b0,3'b000,3'b000,1'b0,4'd9},  // R9 page 3 ok
    '{4'b0000,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b000,1'b0,4'd9},  // R9
    '{4'b0100,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b000,1'b0,4'd9},  // R9
    '{4'b0100,1'b1,1'b1,16'h1000,1'b0,5'd0,1'b0,3'b000,3'b001,1'b0,4'd9},  // R9 page 2 refused
    '{4'b0000,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b001,1'b0,4'd11}, // R11 sticky
    '{4'b1000,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b101,1'b0,4'd8},  // R8
    '{4'b1000,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b001,3'b100,1'b0,4'd11}, // R11 partial
    '{4'b0000,1'b1,1'b1,16'h0000,1'b0,5'd0,1'b0,3'b100,3'b100,1'b0,4'd11}, // R11 set wins
    '{4'b0000,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b111,3'b000,1'b0,4'd11}  // R11
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        ctl_prog, ctl_fast, ctl_perase, ctl_merase, sec_ok, wr_en;
  logic [15:0] wr_addr;
  logic        perase_done, merase_done, clr_we;
  logic [4:0]  perase_page;
  logic [2:0]  clr_mask;
  logic        err_seq, err_align, err_miss, illegal_pulse;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  flash_seq_guard u_flash_seq_guard (
    .clk           (clk),
    .rst           (rst),
    .ctl_prog      (ctl_prog),
    .ctl_fast      (ctl_fast),
    .ctl_perase    (ctl_perase),
    .ctl_merase    (ctl_merase),
    .sec_ok        (sec_ok),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .perase_done   (perase_done),
    .perase_page   (perase_page),
    .merase_done   (merase_done),
    .clr_we        (clr_we),
    .clr_mask      (clr_mask),
    .err_seq       (err_seq),
    .err_align     (err_align),
    .err_miss      (err_miss),
    .illegal_pulse (illegal_pulse)
  );

  task automatic chk(input int rq, input logic [3:0] exp);
    logic [3:0] act;
    act = {err_seq, err_align, err_miss, illegal_pulse};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual %b expected %b (seq align miss ill)", rq, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    {ctl_prog, ctl_fast, ctl_perase, ctl_merase} = v.ctl;
    sec_ok      = v.sec;
    wr_en       = v.wr;
    wr_addr     = v.addr;
    perase_done = v.pd;
    perase_page = v.pp;
    merase_done = v.md;
    clr_we      = (v.clr != 3'b000);
    clr_mask    = v.clr;
  endtask

  localparam vec_t IDLE = '{4'b0000,1'b1,1'b0,16'h0000,1'b0,5'd0,1'b0,3'b000,3'b000,1'b0,4'd0};

  initial begin
    rst = 1'b1;
    drive(IDLE);
    repeat (3) @(posedge clk);
    #1;
    chk(12, 4'b0000); // R12 reset state
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(posedge clk);
      #1;
      chk(int'(VEC[i].rq), {VEC[i].ef, VEC[i].ei});
    end

    // R12: reset clears flags and the mass-erase history
    @(negedge clk);
    drive(IDLE);
    wr_en = 1'b1;
    @(posedge clk);
    #1;
    chk(3, 4'b1000);
    @(negedge clk);
    drive(IDLE);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk(12, 4'b0000);
    @(negedge clk);
    rst = 1'b0;
    ctl_fast = 1'b1;
    @(posedge clk);
    #1;
    chk(12, 4'b1000); // R12: fast rise refused, mass erase forgotten
    @(negedge clk);
    drive(IDLE);
    clr_we = 1'b1;
    clr_mask = 3'b111;
    @(posedge clk);
    #1;
    chk(11, 4'b0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      $display("FAIL R12 watchdog expired actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule